// File: doc/BRIEF.md
# Boot-Aliased System Address Decoder

This block turns a 32-bit bus address into a one-hot region select for a small microcontroller memory map. The map holds program flash, a factory boot memory, a small option-byte area, SRAM and three peripheral windows. Every address outside these ranges is a hole, and an access to a hole raises a decode error. The top three address bits pick one of eight equal 512 MB blocks. Only blocks 0, 1 and 2 contain any region.

The lowest 512 KB of the space is an alias window. Its target depends on two boot-select pins, which are captured while reset is held and then frozen. An alias access asserts the select of the target region, and its local offset is taken relative to that target. If the alias address lies beyond the end of a target that is smaller than the window, the access is a decode error. All outputs are registered and appear one clock cycle after the access is presented. Bus protocol, wait states and the memories themselves are handled elsewhere.

Top module: `sys_addr_decode`

## Requirements
- R1: An access in 0x0800_0000..0x0807_FFFF asserts region_sel bit 0 (flash), with local_off = addr - 0x0800_0000.
- R2: An access in 0x1FFF_F000..0x1FFF_F7FF asserts region_sel bit 1 (boot memory). An access in 0x1FFF_F800..0x1FFF_F80F asserts region_sel bit 2 (option bytes). In both cases local_off is relative to the region start.
- R3: An access in 0x2000_0000..0x2000_FFFF asserts region_sel bit 3 (SRAM), with local_off relative to 0x2000_0000.
- R4: Accesses in the three peripheral windows assert region_sel bits 4, 5 and 6, with local_off relative to each window's start. The windows are 0x4000_0000..0x4000_77FF, 0x4001_0000..0x4001_3FFF and 0x4001_8000..0x4002_33FF.
- R5: A valid access to any address outside the listed ranges sets decode_err for that one result cycle, with region_sel all zero and local_off zero. Blocks 3 to 7 (addr[31:29] >= 3) are wholly reserved.
- R6: When the latched boot_sel[0] is 0, an alias access (addr < 0x0008_0000) asserts bit 0, with local_off = addr.
- R7: When the latched boot_sel is 2'b01, an alias access below 0x800 asserts bit 1, with local_off = addr. An alias access from 0x800 upward is a decode error.
- R8: When the latched boot_sel is 2'b11, an alias access below 0x1_0000 asserts bit 3, with local_off = addr. An alias access from 0x1_0000 upward is a decode error.
- R9: boot_sel is sampled on every clock edge while rst_n is low. The value taken at the last such edge governs the alias until the next reset, and later changes on boot_sel have no effect.
- R10: Results appear exactly one clock after the access. A cycle with valid low yields region_sel zero, decode_err low and local_off zero. Reset clears all outputs.
- R11: At most one region_sel bit is set in any cycle. Every valid access yields exactly one outcome: either one select bit or decode_err.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset. Boot pins are sampled while it is low. |
| valid | input | 1 | Access strobe for addr |
| addr | input | 32 | Bus address |
| boot_sel | input | 2 | Boot-select pins. Bit 0 = 0 selects flash, 01 selects boot memory, 11 selects SRAM. |
| region_sel | output | 7 | One-hot region select, registered |
| local_off | output | 32 | Offset inside the selected region, registered |
| decode_err | output | 1 | Reserved-space access flag, registered |

## Verification
The assertions assume that valid is driven low throughout reset. They also assume that valid and addr are settled before each rising edge, so each registered result belongs to exactly one access. The bench changes inputs only on falling edges, and holds valid low whenever rst_n is low. It also changes boot_sel after reset release to show that the captured mode stays frozen. Addresses are chosen at each region's first and last byte and one byte beyond, including the alias limits under every boot mode.

// File: rtl/sad_pkg.sv
package sad_pkg;
   localparam int unsigned NREG      = 7;
   localparam int unsigned RG_FLASH  = 0;
   localparam int unsigned RG_SYSMEM = 1;
   localparam int unsigned RG_OPTION = 2;
   localparam int unsigned RG_SRAM   = 3;
   localparam int unsigned RG_PER0   = 4;
   localparam int unsigned RG_PER1   = 5;
   localparam int unsigned RG_PER2   = 6;

   typedef enum logic [1:0] {
      BOOT_FLASH  = 2'd0,
      BOOT_SYSMEM = 2'd1,
      BOOT_SRAM   = 2'd2
   } boot_mode_t;

   // pins[0]==0 -> flash; pins==01 -> boot memory; pins==11 -> SRAM
   function automatic boot_mode_t pins_to_mode(input logic [1:0] pins);
      if (!pins[0])     return BOOT_FLASH;
      else if (!pins[1]) return BOOT_SYSMEM;
      else              return BOOT_SRAM;
   endfunction
endpackage

// File: rtl/sad_boot_latch.sv
module sad_boot_latch
   import sad_pkg::*;
#(
   parameter int unsigned PIN_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [PIN_W-1:0] pins,
   output boot_mode_t       mode
);
   generate
      if (PIN_W != 2) begin : g_bad_w
         $error("sad_boot_latch: PIN_W must be 2");
      end
   endgenerate

   // Sampled on every edge while reset is held; frozen once it is released.
   always_ff @(posedge clk) begin
      if (!rst_n) mode <= pins_to_mode(pins[1:0]);
   end
endmodule

// File: rtl/sad_window_match.sv
module sad_window_match #(
   parameter int unsigned   AW   = 32,
   parameter logic [AW-1:0] BASE = '0,
   parameter logic [AW-1:0] SIZE = 1
) (
   input  logic [AW-1:0] addr,
   output logic          hit,
   output logic [AW-1:0] off
);
   localparam int unsigned   BLK_W   = 3;
   localparam logic [AW-1:0] LAST    = BASE + SIZE - 1'b1;
   localparam logic [BLK_W-1:0] BLK  = BASE[AW-1 -: BLK_W];

   generate
      if (SIZE == '0) begin : g_bad_size
         $error("sad_window_match: SIZE must be nonzero");
      end
      if (LAST[AW-1 -: BLK_W] != BLK) begin : g_bad_span
         $error("sad_window_match: window crosses a 512 MB block");
      end
   endgenerate

   logic          blk_ok;
   logic [AW-1:0] diff;

   always_comb begin
      blk_ok = (addr[AW-1 -: BLK_W] == BLK);
      diff   = addr - BASE;
      hit    = blk_ok && (addr >= BASE) && (diff < SIZE);
      off    = hit ? diff : '0;
   end
endmodule

// File: rtl/sad_alias_resolve.sv
module sad_alias_resolve
   import sad_pkg::*;
#(
   parameter int unsigned   AW          = 32,
   parameter logic [AW-1:0] ALIAS_SIZE  = 32'h0008_0000,
   parameter logic [AW-1:0] FLASH_SIZE  = 32'h0008_0000,
   parameter logic [AW-1:0] SYSMEM_SIZE = 32'h0000_0800,
   parameter logic [AW-1:0] SRAM_SIZE   = 32'h0001_0000
) (
   input  logic [AW-1:0]   addr,
   input  boot_mode_t      mode,
   output logic            in_win,
   output logic            fits,
   output logic [NREG-1:0] tgt_sel
);
   generate
      if (ALIAS_SIZE == '0) begin : g_bad_alias
         $error("sad_alias_resolve: ALIAS_SIZE must be nonzero");
      end
   endgenerate

   logic [AW-1:0] tgt_size;

   always_comb begin
      tgt_sel = '0;
      unique case (mode)
         BOOT_SYSMEM: begin tgt_size = SYSMEM_SIZE; tgt_sel[RG_SYSMEM] = 1'b1; end
         BOOT_SRAM:   begin tgt_size = SRAM_SIZE;   tgt_sel[RG_SRAM]   = 1'b1; end
         default:     begin tgt_size = FLASH_SIZE;  tgt_sel[RG_FLASH]  = 1'b1; end
      endcase
      in_win = (addr < ALIAS_SIZE);
      fits   = in_win && (addr < tgt_size);
   end
endmodule

// File: rtl/sys_addr_decode.sv
module sys_addr_decode
   import sad_pkg::*;
#(
   parameter int unsigned   AW          = 32,
   parameter int unsigned   PIN_W       = 2,
   parameter logic [AW-1:0] ALIAS_SIZE  = 32'h0008_0000,
   parameter logic [AW-1:0] FLASH_BASE  = 32'h0800_0000,
   parameter logic [AW-1:0] FLASH_SIZE  = 32'h0008_0000,
   parameter logic [AW-1:0] SYSMEM_BASE = 32'h1FFF_F000,
   parameter logic [AW-1:0] SYSMEM_SIZE = 32'h0000_0800,
   parameter logic [AW-1:0] OPTION_BASE = 32'h1FFF_F800,
   parameter logic [AW-1:0] OPTION_SIZE = 32'h0000_0010,
   parameter logic [AW-1:0] SRAM_BASE   = 32'h2000_0000,
   parameter logic [AW-1:0] SRAM_SIZE   = 32'h0001_0000,
   parameter logic [AW-1:0] PER0_BASE   = 32'h4000_0000,
   parameter logic [AW-1:0] PER0_SIZE   = 32'h0000_7800,
   parameter logic [AW-1:0] PER1_BASE   = 32'h4001_0000,
   parameter logic [AW-1:0] PER1_SIZE   = 32'h0000_4000,
   parameter logic [AW-1:0] PER2_BASE   = 32'h4001_8000,
   parameter logic [AW-1:0] PER2_SIZE   = 32'h0000_B400
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            valid,
   input  logic [AW-1:0]   addr,
   input  logic [PIN_W-1:0] boot_sel,
   output logic [NREG-1:0] region_sel,
   output logic [AW-1:0]   local_off,
   output logic            decode_err
);
   localparam logic [NREG-1:0][AW-1:0] RG_BASE =
      {PER2_BASE, PER1_BASE, PER0_BASE, SRAM_BASE, OPTION_BASE, SYSMEM_BASE, FLASH_BASE};
   localparam logic [NREG-1:0][AW-1:0] RG_SIZE =
      {PER2_SIZE, PER1_SIZE, PER0_SIZE, SRAM_SIZE, OPTION_SIZE, SYSMEM_SIZE, FLASH_SIZE};

   generate
      if (AW != 32) begin : g_bad_aw
         $error("sys_addr_decode: AW must be 32");
      end
      if (ALIAS_SIZE > FLASH_BASE) begin : g_bad_alias
         $error("sys_addr_decode: alias window overlaps flash");
      end
   endgenerate

   boot_mode_t boot_mode;

   sad_boot_latch #(.PIN_W(PIN_W)) u_boot (
      .clk   (clk),
      .rst_n (rst_n),
      .pins  (boot_sel),
      .mode  (boot_mode)
   );

   logic [NREG-1:0]          win_hit;
   logic [NREG-1:0][AW-1:0]  win_off;

   generate
      for (genvar gi = 0; gi < NREG; gi++) begin : g_win
         sad_window_match #(
            .AW   (AW),
            .BASE (RG_BASE[gi]),
            .SIZE (RG_SIZE[gi])
         ) u_match (
            .addr (addr),
            .hit  (win_hit[gi]),
            .off  (win_off[gi])
         );
      end
   endgenerate

   logic            al_in, al_fits;
   logic [NREG-1:0] al_sel;

   sad_alias_resolve #(
      .AW          (AW),
      .ALIAS_SIZE  (ALIAS_SIZE),
      .FLASH_SIZE  (FLASH_SIZE),
      .SYSMEM_SIZE (SYSMEM_SIZE),
      .SRAM_SIZE   (SRAM_SIZE)
   ) u_alias (
      .addr    (addr),
      .mode    (boot_mode),
      .in_win  (al_in),
      .fits    (al_fits),
      .tgt_sel (al_sel)
   );

   logic [NREG-1:0] nxt_sel;
   logic [AW-1:0]   nxt_off;
   logic            nxt_err;
   logic [AW-1:0]   mux_off;

   always_comb begin
      mux_off = '0;
      for (int i = 0; i < NREG; i++) begin
         mux_off = mux_off | win_off[i];
      end
      nxt_sel = '0;
      nxt_off = '0;
      nxt_err = 1'b0;
      if (valid) begin
         if (al_in) begin
            if (al_fits) begin
               nxt_sel = al_sel;
               nxt_off = addr;
            end else begin
               nxt_err = 1'b1;
            end
         end else if (win_hit != '0) begin
            nxt_sel = win_hit;
            nxt_off = mux_off;
         end else begin
            nxt_err = 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         region_sel <= '0;
         local_off  <= '0;
         decode_err <= 1'b0;
      end else begin
         region_sel <= nxt_sel;
         local_off  <= nxt_off;
         decode_err <= nxt_err;
      end
   end
endmodule

// File: rtl/sad_checker.sv
module sad_checker
   import sad_pkg::*;
#(
   parameter int unsigned AW = 32
) (
   input logic            clk,
   input logic            rst_n,
   input logic            valid,
   input logic [NREG-1:0] region_sel,
   input logic [AW-1:0]   local_off,
   input logic            decode_err,
   input boot_mode_t      boot_mode
);
   assert_onehot_sel_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(region_sel));

   assert_err_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
      decode_err |-> (region_sel == '0 && local_off == '0));

   assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !valid |=> (region_sel == '0 && !decode_err && local_off == '0));

   assert_one_outcome_R11: assert property (@(posedge clk) disable iff (!rst_n)
      valid |=> ($countones({region_sel, decode_err}) == 1));

   assert_boot_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> $stable(boot_mode));
endmodule

bind sys_addr_decode sad_checker #(.AW(AW)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .valid      (valid),
   .region_sel (region_sel),
   .local_off  (local_off),
   .decode_err (decode_err),
   .boot_mode  (boot_mode)
);

// File: tb/sim_sys_addr_decode.sv
module sim_sys_addr_decode;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        valid = 1'b0;
   logic [31:0] addr = '0;
   logic [1:0]  boot_sel = 2'b00;
   logic [6:0]  region_sel;
   logic [31:0] local_off;
   logic        decode_err;

   always #5 clk = ~clk;

   sys_addr_decode u0 (
      .clk(clk), .rst_n(rst_n), .valid(valid), .addr(addr), .boot_sel(boot_sel),
      .region_sel(region_sel), .local_off(local_off), .decode_err(decode_err)
   );

   typedef struct {
      logic [6:0]  sel;
      logic [31:0] off;
      logic        err;
      string       tag;
   } exp_t;

   exp_t        q[$];
   int          n_run = 0;
   int          n_fail = 0;
   logic        mon_en = 1'b0;
   logic [1:0]  boot_lat = 2'b00;

   function automatic exp_t model(input logic [31:0] a, input logic [1:0] bm, input string tag);
      exp_t e;
      e.sel = '0; e.off = '0; e.err = 1'b0; e.tag = tag;
      if (a < 32'h0008_0000) begin
         if (!bm[0]) begin e.sel = 7'b000_0001; e.off = a; end          // R6
         else if (!bm[1]) begin                                          // R7
            if (a < 32'h800) begin e.sel = 7'b000_0010; e.off = a; end else e.err = 1'b1;
         end else begin                                                  // R8
            if (a < 32'h1_0000) begin e.sel = 7'b000_1000; e.off = a; end else e.err = 1'b1;
         end
      end
      else if (a >= 32'h0800_0000 && a <= 32'h0807_FFFF) begin e.sel = 7'b000_0001; e.off = a - 32'h0800_0000; end
      else if (a >= 32'h1FFF_F000 && a <= 32'h1FFF_F7FF) begin e.sel = 7'b000_0010; e.off = a - 32'h1FFF_F000; end
      else if (a >= 32'h1FFF_F800 && a <= 32'h1FFF_F80F) begin e.sel = 7'b000_0100; e.off = a - 32'h1FFF_F800; end
      else if (a >= 32'h2000_0000 && a <= 32'h2000_FFFF) begin e.sel = 7'b000_1000; e.off = a - 32'h2000_0000; end
      else if (a >= 32'h4000_0000 && a <= 32'h4000_77FF) begin e.sel = 7'b001_0000; e.off = a - 32'h4000_0000; end
      else if (a >= 32'h4001_0000 && a <= 32'h4001_3FFF) begin e.sel = 7'b010_0000; e.off = a - 32'h4001_0000; end
      else if (a >= 32'h4001_8000 && a <= 32'h4002_33FF) begin e.sel = 7'b100_0000; e.off = a - 32'h4001_8000; end
      else e.err = 1'b1;                                                 // R5
      return e;
   endfunction

   task automatic acc(input logic [31:0] a, input string tag);
      @(negedge clk);
      addr  = a;
      valid = 1'b1;
      q.push_back(model(a, boot_lat, tag));
   endtask

   task automatic idle(input logic [31:0] a);
      exp_t e;
      @(negedge clk);
      addr  = a;
      valid = 1'b0;
      e.sel = '0; e.off = '0; e.err = 1'b0; e.tag = "R10";
      q.push_back(e);
   endtask

   task automatic drain();
      @(negedge clk);
      valid = 1'b0;
      while (q.size() != 0) @(negedge clk);
   endtask

   task automatic do_reset(input logic [1:0] pins);
      mon_en   = 1'b0;
      valid    = 1'b0;
      rst_n    = 1'b0;
      boot_sel = pins;
      repeat (3) @(negedge clk);
      n_run++;
      if (region_sel !== '0 || local_off !== '0 || decode_err !== 1'b0) begin
         n_fail++;
         $display("FAIL R10 reset state: sel=%b off=%h err=%b expected 0/0/0",
                  region_sel, local_off, decode_err);
      end
      rst_n    = 1'b1;
      boot_lat = pins;
      mon_en   = 1'b1;
   endtask

   // Monitor: one result per cycle, one clock after the access was driven.
   always @(posedge clk) begin
      #1;
      if (mon_en && q.size() != 0) begin
         exp_t e;
         e = q.pop_front();
         n_run++;
         if (region_sel !== e.sel || local_off !== e.off || decode_err !== e.err) begin
            n_fail++;
            $display("FAIL %s: sel=%b off=%h err=%b expected sel=%b off=%h err=%b",
                     e.tag, region_sel, local_off, decode_err, e.sel, e.off, e.err);
         end
      end
   end

   initial begin
      #1_000_000;
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      do_reset(2'b00);
      // R1 flash edges
      acc(32'h0800_0000, "R1"); acc(32'h0807_FFFF, "R1"); acc(32'h0804_1234, "R1");
      acc(32'h0808_0000, "R5");
      // R2 boot memory and option bytes
      acc(32'h1FFF_F000, "R2"); acc(32'h1FFF_F7FF, "R2");
      acc(32'h1FFF_F800, "R2"); acc(32'h1FFF_F80F, "R2");
      acc(32'h1FFF_F810, "R5"); acc(32'h1FFF_EFFF, "R5");
      // R3 SRAM
      acc(32'h2000_0000, "R3"); acc(32'h2000_FFFF, "R3"); acc(32'h2001_0000, "R5");
      // R4 peripheral windows
      acc(32'h4000_0000, "R4"); acc(32'h4000_77FF, "R4"); acc(32'h4000_7800, "R5");
      acc(32'h4001_0000, "R4"); acc(32'h4001_3FFF, "R4"); acc(32'h4001_4000, "R5");
      acc(32'h4001_7FFF, "R5"); acc(32'h4001_8000, "R4"); acc(32'h4002_33FF, "R4");
      acc(32'h4002_3400, "R5");
      // R5 wholly reserved upper blocks
      acc(32'h6000_0000, "R5"); acc(32'hE000_ED00, "R5"); acc(32'hFFFF_FFFF, "R5");
      // R10 idle cycles interleaved
      idle(32'h0800_0000); acc(32'h2000_0040, "R10"); idle(32'h4000_0000);
      // R6 alias to flash
      acc(32'h0000_0000, "R6"); acc(32'h0007_FFFF, "R6"); acc(32'h0008_0000, "R5");
      // R9 pin change after reset has no effect
      @(negedge clk); boot_sel = 2'b11;
      acc(32'h0000_4000, "R9"); acc(32'h0004_0000, "R9");
      drain();

      do_reset(2'b01);                       // R7
      acc(32'h0000_0000, "R7"); acc(32'h0000_07FF, "R7"); acc(32'h0000_0800, "R7");
      acc(32'h1FFF_F123, "R7");
      @(negedge clk); boot_sel = 2'b00;
      acc(32'h0000_0100, "R9"); acc(32'h0000_1000, "R9");
      drain();

      do_reset(2'b11);                       // R8
      acc(32'h0000_0000, "R8"); acc(32'h0000_FFFF, "R8"); acc(32'h0001_0000, "R8");
      acc(32'h0007_FFFF, "R8"); idle(32'h0); acc(32'h0000_8000, "R11");
      drain();

      do_reset(2'b10);                       // R6: bit0 low selects flash
      acc(32'h0000_0800, "R6"); acc(32'h0005_5555, "R6"); acc(32'h0800_0010, "R11");
      drain();

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule